// File: doc/BRIEF.md
# Radix-4 Booth Multiplier with Early Termination

This block multiplies two 32-bit two's-complement numbers over several clock cycles. It produces the low 32 bits of the product. Each iteration retires two bits of the multiplier. The multiplier is scanned in overlapping 3-bit windows that advance by two positions, with an implicit zero below bit 0. Each window is recoded into a signed digit in the set {-2, -1, 0, +1, +2}. The matching multiple of the multiplicand is added into an accumulator, and the multiplicand register shifts left by two places.

The block stops as soon as the multiplier bits not yet scanned, together with the top bit of the last window, are all identical. Every later digit would then be zero. Small positive and small negative multipliers therefore finish after a few iterations, and a full-width multiplier takes at most 16. A client pulses `start` with the operands while the block is idle. It watches `busy`, and reads `product` in the cycle where `done` is high. The result stays on `product` until the next operation completes.

Top module: `booth_r4_mult`

## Requirements
- R1: While `rst` is high on a clock edge, `busy` and `done` go low and `product` goes to zero.
- R2: When `start` is high and `busy` is low on a clock edge, the block captures `op_a` (multiplicand) and `op_b` (multiplier), and `busy` is high after that edge.
- R3: The completed `product` equals the low 32 bits of the signed product of `op_a` and `op_b`.
- R4: Each 3-bit window w = {b[2k+1], b[2k], b[2k-1]} (with b[-1] = 0) selects the digit 0 for 000 and 111, +1 for 001 and 010, +2 for 011, -2 for 100, and -1 for 101 and 110. The digit carries weight 4^k.
- R5: The operation runs n iterations, one per clock edge after the capturing edge. n is the smallest value of at least 1 for which bits 31 down to 2n-1 of the multiplier are all equal. `done` is high after the n-th edge that follows the capturing edge.
- R6: No operation runs more than 16 iterations; a multiplier such as 0x7FFFFFFF or 0x80000000 takes exactly 16.
- R7: `done` is high for exactly one cycle per operation, and `busy` falls on the same edge that raises `done`.
- R8: A `start` pulse while `busy` is high has no effect on the running operation and does not begin another one.
- R9: `product` changes only on the edge that raises `done`, and holds its value in every other cycle.
- R10: A multiplier of 0, 1 or -1 completes in a single iteration.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a multiplication when idle |
| op_a | input | 32 | Multiplicand, two's complement |
| op_b | input | 32 | Multiplier, two's complement |
| busy | output | 1 | Iterations in progress |
| done | output | 1 | One-cycle pulse when `product` is updated |
| product | output | 32 | Low 32 bits of the signed product |

## Verification
The assertions assume the following:
- `rst` is held high from time zero until the first edges have put every register into a known state.
- `start` may be driven at any level in any cycle, including while the block is busy.
- The operands matter only on the capturing edge.

The stimulus follows these assumptions. It applies reset first and changes inputs only on falling edges. It presents `start` only once the previous result has appeared, except for deliberate pulses while busy that carry different operands. The multipliers are chosen to cover every iteration count from 1 to 16: random values are arithmetic-shifted by random amounts, and fixed patterns are added for alternating bits and for the extremes.

// File: rtl/booth_r4_pkg.sv
package booth_r4_pkg;

  // Signed digit selected by one 3-bit window of the multiplier
  typedef enum logic [2:0] {
    BD_ZERO,
    BD_POS1,
    BD_POS2,
    BD_NEG1,
    BD_NEG2
  } booth_digit_e;

endpackage

// File: rtl/booth_r4_recode.sv
module booth_r4_recode
  import booth_r4_pkg::*;
(
  input  logic [2:0]   win,
  output booth_digit_e dig
);

  always_comb begin
    case (win)
      3'b001, 3'b010: dig = BD_POS1;
      3'b011:         dig = BD_POS2;
      3'b100:         dig = BD_NEG2;
      3'b101, 3'b110: dig = BD_NEG1;
      default:        dig = BD_ZERO;
    endcase
  end

endmodule

// File: rtl/booth_r4_ppgen.sv
module booth_r4_ppgen
  import booth_r4_pkg::*;
#(
  parameter int W = 32
) (
  input  booth_digit_e dig,
  input  logic [W-1:0] mcand,
  output logic [W-1:0] pp
);

  logic [W-1:0] twice;

  assign twice = {mcand[W-2:0], 1'b0};

  always_comb begin
    case (dig)
      BD_POS1: pp = mcand;
      BD_POS2: pp = twice;
      BD_NEG1: pp = W'(0) - mcand;
      BD_NEG2: pp = W'(0) - twice;
      default: pp = '0;
    endcase
  end

endmodule

// File: rtl/booth_r4_uniform.sv
module booth_r4_uniform #(
  parameter int N = 33
) (
  input  logic [N-1:0] vec,
  output logic         same
);

  // True when the remaining multiplier bits are pure sign extension
  assign same = (vec == '0) || (&vec);

endmodule

// File: rtl/booth_r4_mult.sv
module booth_r4_mult
  import booth_r4_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] product
);

  localparam int ITERS = W / 2;
  localparam int CW    = $clog2(ITERS + 1);

  logic [W-1:0]  mcand_q;
  logic [W:0]    mpl_q;
  logic [W-1:0]  acc_q;
  logic [CW-1:0] cnt_q;
  logic          busy_q;
  logic          done_q;
  logic [W-1:0]  prod_q;

  booth_digit_e  dig;
  logic [W-1:0]  pp;
  logic [W-1:0]  acc_nxt;
  logic [W:0]    mpl_nxt;
  logic          rest_same;
  logic          last_iter;

  booth_r4_recode u_recode (
    .win (mpl_q[2:0]),
    .dig (dig)
  );

  booth_r4_ppgen #(.W(W)) u_ppgen (
    .dig   (dig),
    .mcand (mcand_q),
    .pp    (pp)
  );

  assign acc_nxt = acc_q + pp;
  assign mpl_nxt = {{2{mpl_q[W]}}, mpl_q[W:2]};

  booth_r4_uniform #(.N(W + 1)) u_uniform (
    .vec  (mpl_nxt),
    .same (rest_same)
  );

  assign last_iter = rest_same || (cnt_q == CW'(ITERS - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      mcand_q <= '0;
      mpl_q   <= '0;
      acc_q   <= '0;
      cnt_q   <= '0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      prod_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (busy_q) begin
        acc_q   <= acc_nxt;
        mcand_q <= {mcand_q[W-3:0], 2'b00};
        mpl_q   <= mpl_nxt;
        cnt_q   <= cnt_q + 1'b1;
        if (last_iter) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          prod_q <= acc_nxt;
        end
      end else if (start) begin
        mcand_q <= op_a;
        mpl_q   <= {op_b, 1'b0};
        acc_q   <= '0;
        cnt_q   <= '0;
        busy_q  <= 1'b1;
      end
    end
  end

  assign busy    = busy_q;
  assign done    = done_q;
  assign product = prod_q;

  // R2: an idle start begins a fresh run
  p_load_r2: assert property (@(posedge clk) disable iff (rst)
    (!busy_q && start) |=> (busy_q && cnt_q == '0));

  // R5: a result only follows an iteration
  p_done_after_busy_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(done_q) |-> $past(busy_q));

  // R6: iteration count stays below the cap while running
  p_iter_cap_r6: assert property (@(posedge clk) disable iff (rst)
    busy_q |-> (cnt_q < CW'(ITERS)));

  // R7: done is a single-cycle pulse, exclusive with busy
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);

  p_busy_done_excl_r7: assert property (@(posedge clk) disable iff (rst)
    !(busy_q && done_q));

  // R9: the result register holds outside completion
  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !done_q |-> $stable(prod_q));

endmodule

// File: tb/test_booth_r4_mult.sv
module test_booth_r4_mult;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic [W-1:0] op_a = '0;
  logic [W-1:0] op_b = '0;
  logic         busy;
  logic         done;
  logic [W-1:0] product;

  booth_r4_mult #(.W(W)) i_booth_r4_mult (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .op_a    (op_a),
    .op_b    (op_b),
    .busy    (busy),
    .done    (done),
    .product (product)
  );

  always #5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    logic [W-1:0] exp;
    int           due;
    string        tag;
  } item_t;

  item_t        exp_q[$];
  int           n_checks = 0;
  int           n_err = 0;
  logic [W-1:0] last_prod = '0;
  logic         prev_done = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Iteration count from R5
  function automatic int iters(input logic [W-1:0] m);
    for (int n = 1; n <= W / 2; n++) begin
      bit same = 1'b1;
      for (int i = 2 * n - 1; i < W; i++)
        if (m[i] != m[W-1]) same = 1'b0;
      if (same) return n;
    end
    return W / 2;
  endfunction

  // Driver: pushes the expected result, then issues the operation
  task automatic run_op(input logic [W-1:0] a, input logic [W-1:0] b,
                        input string tag, input bit poke);
    item_t it;
    logic signed [2*W-1:0] full;
    int k;
    @(negedge clk);
    full   = $signed(a) * $signed(b);
    it.exp = full[W-1:0];
    it.due = cyc + 1 + iters(b);
    it.tag = tag;
    exp_q.push_back(it);
    start = 1'b1;
    op_a  = a;
    op_b  = b;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R2", "busy after start", W'(busy), W'(1));
    if (poke) begin
      // R8: start while busy must be ignored
      start = 1'b1;
      op_a  = ~a;
      op_b  = b ^ 32'h0F0F_0F0F;
      @(negedge clk);
      start = 1'b0;
    end
    k = 0;
    while (!done && k < 40) begin
      @(negedge clk);
      k++;
    end
    @(negedge clk);
    if (poke)
      check(busy == 1'b0, "R8", "no restart from busy start", W'(busy), W'(0));
  endtask

  // Monitor: pops and compares on each completion
  always @(negedge clk) begin
    if (!rst) begin
      if (done) begin
        check(!prev_done, "R7", "done pulse width", W'(prev_done), W'(0));
        check(!busy, "R7", "busy low with done", W'(busy), W'(0));
        if (exp_q.size() == 0) begin
          check(1'b0, "R3", "unexpected done", product, '0);
        end else begin
          item_t it;
          it = exp_q.pop_front();
          check(product == it.exp, it.tag, "product", product, it.exp);
          check(cyc == it.due, "R5", "completion cycle", W'(cyc), W'(it.due));
        end
        last_prod = product;
      end else if (product != last_prod) begin
        check(1'b0, "R9", "product changed without done", product, last_prod);
      end
      prev_done = done;
    end
  end

  // Watchdog
  always @(posedge clk) begin
    if (cyc == 20000) begin
      n_checks++;
      n_err++;
      $display("FAIL watchdog: actual %0d expected completion", cyc);
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(busy == 1'b0, "R1", "busy in reset", W'(busy), W'(0));
    check(done == 1'b0, "R1", "done in reset", W'(done), W'(0));
    check(product == '0, "R1", "product in reset", product, '0);
    rst = 1'b0;

    run_op(32'h1234_5678, 32'h0000_0000, "R10", 1'b0);
    run_op(32'hDEAD_BEEF, 32'h0000_0001, "R10", 1'b0);
    run_op(32'h7654_3210, 32'hFFFF_FFFF, "R10", 1'b0);
    run_op(32'h0000_0007, 32'h0000_0003, "R4", 1'b0);
    run_op(32'hFFFF_FFF9, 32'h0000_0002, "R4", 1'b0);
    run_op(32'h1357_9BDF, 32'h5555_5555, "R4", 1'b0);
    run_op(32'h2468_ACE0, 32'hAAAA_AAAA, "R4", 1'b0);
    run_op(32'h0001_0003, 32'h7FFF_FFFF, "R6", 1'b0);
    run_op(32'h8000_0000, 32'h8000_0000, "R6", 1'b0);
    run_op(32'h8000_0000, 32'hFFFF_FFFF, "R3", 1'b0);
    run_op(32'h0BAD_F00D, 32'h0000_0123, "R8", 1'b1);
    run_op(32'hC0FF_EE00, 32'hFFFF_FF80, "R8", 1'b1);

    for (int t = 0; t < 40; t++) begin
      logic [W-1:0] a;
      logic [W-1:0] b;
      a = $urandom;
      b = $urandom;
      b = $signed(b) >>> ($urandom % W);
      run_op(a, b, "R3", (t % 5) == 0);
    end

    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R5", "outstanding results", W'(exp_q.size()), W'(0));
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

endmodule